// File: doc/BRIEF.md
# Multi-Mode Timer/Counter Channel

This block is a single timer/counter channel built from an 8-bit low byte and an 8-bit high byte. It advances either once per 12-clock machine cycle, which gives interval timing, or once per qualified falling edge on an external event pin, which gives event counting. A 2-bit mode field selects how the two bytes form the count: a 13-bit counter, a full 16-bit counter, or an 8-bit counter in the low byte that reloads itself from the high byte.

When the active count wraps from all ones to zero, the channel emits a one-clock overflow pulse and keeps counting. Software enables the channel with `run_en`. If it also sets `gate_en`, counting is allowed only while the synchronized gating pin is high. Software can write either byte directly, and a write always wins over an increment that falls in the same cycle.

Top module: `tmr_channel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `lo_q`, `hi_q` and `ovf_pulse` are all 0.
- R2: When `count_sel`=0 (timer), the count advances exactly once every 12 clocks.
- R3: When `count_sel`=1 (counter), the count advances once for each high-to-low transition of `evt_pin`, provided each level is held for at least one machine cycle plus two clocks. A steady level does not advance the count, and neither does a rising edge.
- R4: With `run_en`=0 the count holds. With `gate_en`=1 the count also holds while `gate_pin` is low. It counts again once `gate_pin` is high.
- R5: The `mode` encodings are 2'b00 = 13-bit, 2'b01 = 16-bit, 2'b10 = 8-bit auto-reload and 2'b11 = hold. In hold mode neither byte changes and no overflow occurs.
- R6: In mode 2'b00 the count is {`hi_q`, `lo_q[4:0]`}. Bits `lo_q[7:5]` keep their written value and take no part in counting. For example, 0xFF/0xFE wraps after 2 increments to `hi_q`=0x00 and `lo_q`=0xE0.
- R7: In mode 2'b01 the count is {`hi_q`, `lo_q`}. A start value of 0xFF9C wraps to 0x0000 exactly 100 increments after it is loaded.
- R8: In mode 2'b10 only `lo_q` counts. On the step after 0xFF, `lo_q` is loaded with `hi_q` and `hi_q` stays unchanged. The wrap period is 256 − `hi_q` increments, so a value of 0xC0 gives 64 increments (768 clocks).
- R9: `ovf_pulse` is high for exactly one clock, in the cycle after the edge that wraps the count. Counting continues afterwards, and the next increment follows 12 clocks later in timer mode.
- R10: A write to either byte takes the written value, even when the channel is stopped. Any increment due in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run enable |
| gate_en | input | 1 | When 1, counting also needs `gate_pin` high |
| count_sel | input | 1 | 0 = count machine cycles, 1 = count event-pin falling edges |
| mode | input | 2 | Count geometry (see R5) |
| evt_pin | input | 1 | Asynchronous event input |
| gate_pin | input | 1 | Asynchronous gating input |
| lo_we | input | 1 | Low-byte write strobe |
| lo_wdata | input | 8 | Low-byte write data |
| hi_we | input | 1 | High-byte write strobe |
| hi_wdata | input | 8 | High-byte write data |
| lo_q | output | 8 | Low count byte |
| hi_q | output | 8 | High count byte |
| ovf_pulse | output | 1 | One-clock overflow-flag set pulse |

## Verification
The assertions assume that `mode` is set before counting starts and is left unchanged through a wrap, and that write strobes last a single clock. They also assume the two pins are asynchronous levels that stay put well beyond the synchronizer depth. The bench changes `mode`, `count_sel` and `gate_en` only while `run_en` is low or just before it preloads the bytes. It holds each event level for 24 clocks, which is two machine cycles, so every edge is seen by one prescaler tick and no check depends on the phase at which a pin moved.

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       gate_en,
  input  logic       count_sel,
  input  logic [1:0] mode,
  input  logic       evt_pin,
  input  logic       gate_pin,
  input  logic       lo_we,
  input  logic [7:0] lo_wdata,
  input  logic       hi_we,
  input  logic [7:0] hi_wdata,
  output logic [7:0] lo_q,
  output logic [7:0] hi_q,
  output logic       ovf_pulse
);
  localparam int PW = $clog2(PRESCALE);

  logic [PW-1:0]          phase;
  logic [SYNC_STAGES-1:0] evt_sr, gate_sr;
  logic                   evt_prev;
  logic                   tick, evt_s, gate_s, evt_fall, enabled, step, wrap;
  logic [7:0]             nlo, nhi;
  logic [13:0]            sum13;
  logic [16:0]            sum16;
  logic [8:0]             sum8;

  assign tick     = (phase == PW'(PRESCALE - 1));
  assign evt_s    = evt_sr[SYNC_STAGES-1];
  assign gate_s   = gate_sr[SYNC_STAGES-1];
  assign evt_fall = tick & evt_prev & ~evt_s;
  assign enabled  = run_en & (~gate_en | gate_s);
  assign step     = enabled & (count_sel ? evt_fall : tick) & (mode != 2'b11) & ~lo_we & ~hi_we;

  assign sum13 = {1'b0, hi_q, lo_q[4:0]} + 14'd1;
  assign sum16 = {1'b0, hi_q, lo_q} + 17'd1;
  assign sum8  = {1'b0, lo_q} + 9'd1;

  always_comb begin
    nlo  = lo_q;
    nhi  = hi_q;
    wrap = 1'b0;
    case (mode)
      2'b00: begin
        nlo  = {lo_q[7:5], sum13[4:0]};
        nhi  = sum13[12:5];
        wrap = sum13[13];
      end
      2'b01: begin
        {nhi, nlo} = sum16[15:0];
        wrap       = sum16[16];
      end
      2'b10: begin
        nlo  = sum8[8] ? hi_q : sum8[7:0];
        wrap = sum8[8];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= '0;
      evt_sr    <= '0;
      gate_sr   <= '0;
      evt_prev  <= 1'b0;
      lo_q      <= '0;
      hi_q      <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      phase     <= tick ? '0 : phase + PW'(1);
      evt_sr    <= {evt_sr[SYNC_STAGES-2:0], evt_pin};
      gate_sr   <= {gate_sr[SYNC_STAGES-2:0], gate_pin};
      if (tick) evt_prev <= evt_s;
      ovf_pulse <= step & wrap;
      if (lo_we) lo_q <= lo_wdata;
      if (hi_we) hi_q <= hi_wdata;
      if (step) begin
        lo_q <= nlo;
        hi_q <= nhi;
      end
    end
  end
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_en,
  input logic [1:0] mode,
  input logic       lo_we,
  input logic [7:0] lo_wdata,
  input logic       hi_we,
  input logic       ovf_pulse,
  input logic [7:0] lo_q,
  input logic [7:0] hi_q
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (lo_q == 8'd0 && hi_q == 8'd0 && !ovf_pulse)); // R1
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!run_en && !lo_we && !hi_we) |=> ($stable(lo_q) && $stable(hi_q) && !ovf_pulse)); // R4
  AST_MODE3_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b11 && !lo_we && !hi_we) |=> ($stable(lo_q) && $stable(hi_q) && !ovf_pulse)); // R5
  AST_WRAP13_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (ovf_pulse && $past(mode) == 2'b00) |-> (hi_q == 8'd0 && lo_q[4:0] == 5'd0)); // R6
  AST_WRAP16_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (ovf_pulse && $past(mode) == 2'b01) |-> (hi_q == 8'd0 && lo_q == 8'd0)); // R7
  AST_RELOAD_HI: assert property (@(posedge clk) disable iff (!rst_n) (ovf_pulse && $past(mode) == 2'b10) |-> (lo_q == hi_q)); // R8
  AST_HI_KEPT_MODE2: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b10 && !hi_we) |=> $stable(hi_q)); // R8
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ovf_pulse |=> !ovf_pulse); // R9
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n) lo_we |=> (lo_q == $past(lo_wdata) && !ovf_pulse)); // R10
endmodule

bind tmr_channel tmr_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode(mode), .lo_we(lo_we),
  .lo_wdata(lo_wdata), .hi_we(hi_we), .ovf_pulse(ovf_pulse), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run_en = 0, gate_en = 0, count_sel = 0, evt_pin = 0, gate_pin = 0;
  logic [1:0] mode = 2'b01;
  logic lo_we = 0, hi_we = 0;
  logic [7:0] lo_wdata = 0, hi_wdata = 0;
  logic [7:0] lo_q, hi_q;
  logic ovf_pulse;

  typedef struct { string req; logic [7:0] lo; logic [7:0] hi; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0, cyc = 0, ovf_cyc = 0, ovf_seen = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_channel u_tmr_channel (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .gate_en(gate_en), .count_sel(count_sel),
    .mode(mode), .evt_pin(evt_pin), .gate_pin(gate_pin), .lo_we(lo_we), .lo_wdata(lo_wdata),
    .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_q(lo_q), .hi_q(hi_q), .ovf_pulse(ovf_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic wr(input bit to_hi, input logic [7:0] v);
    @(negedge clk);
    if (to_hi) begin hi_we = 1; hi_wdata = v; end
    else begin lo_we = 1; lo_wdata = v; end
    @(negedge clk);
    lo_we = 0; hi_we = 0;
  endtask

  task automatic push(input string req, input logic [7:0] lo, input logic [7:0] hi);
    exp_t e;
    e.req = req; e.lo = lo; e.hi = hi;
    exp_q.push_back(e);
  endtask

  task automatic wait_lo_change(output int c);
    logic [7:0] old;
    old = lo_q;
    c = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (lo_q != old) begin c = cyc; break; end
    end
  endtask

  task automatic wait_ovf(input int n, input int limit);
    int target;
    target = ovf_seen + n;
    for (int i = 0; i < limit && ovf_seen < target; i++) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && ovf_pulse) begin
      ovf_seen++;
      ovf_cyc = cyc;
      if (exp_q.size() == 0) check(0, "R9 unexpected overflow", {hi_q, lo_q}, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(lo_q == e.lo && hi_q == e.hi, e.req, {hi_q, lo_q}, {e.hi, e.lo});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    int c0, c1, c2;
    logic [7:0] held;
    repeat (5) @(negedge clk);
    check(lo_q == 0 && hi_q == 0 && !ovf_pulse, "R1 reset", {hi_q, lo_q}, 0);
    rst_n = 1;
    @(negedge clk);
    check(lo_q == 0 && hi_q == 0 && !ovf_pulse, "R1 after release", {hi_q, lo_q}, 0);

    // R2: timer rate, 16-bit mode
    run_en = 1;
    wait_lo_change(c0);
    wait_lo_change(c1);
    check(c1 - c0 == 12, "R2 timer period", c1 - c0, 12);

    // R10: write wins over increments, hi kept
    wr(1, 8'h07);
    @(negedge clk);
    lo_we = 1; lo_wdata = 8'h55;
    repeat (30) @(negedge clk);
    lo_we = 0;
    check(lo_q == 8'h55 && hi_q == 8'h07, "R10 write priority", {hi_q, lo_q}, 16'h0755);

    // R4: run low holds, gating
    run_en = 0;
    wr(0, 8'h10); wr(1, 8'h00);
    check(lo_q == 8'h10, "R10 write while stopped", lo_q, 8'h10);
    repeat (40) @(negedge clk);
    check(lo_q == 8'h10, "R4 run low holds", lo_q, 8'h10);
    gate_en = 1; gate_pin = 0; run_en = 1;
    repeat (60) @(negedge clk);
    check(lo_q == 8'h10, "R4 gate low holds", lo_q, 8'h10);
    gate_pin = 1;
    repeat (60) @(negedge clk);
    check(lo_q >= 8'h13 && lo_q <= 8'h15, "R4 gate high counts", lo_q, 8'h14);
    gate_en = 0; gate_pin = 0;

    // R5: hold mode
    mode = 2'b11;
    held = lo_q;
    repeat (50) @(negedge clk);
    check(lo_q == held, "R5 mode 3 holds", lo_q, held);

    // R6: 13-bit mode, top low bits kept
    run_en = 0; mode = 2'b00;
    wr(0, 8'hFE); wr(1, 8'hFF);
    push("R6 13-bit wrap", 8'hE0, 8'h00);
    run_en = 1;
    wait_ovf(1, 60);
    check(ovf_seen == 1, "R6 wrap seen", ovf_seen, 1);
    @(negedge clk);
    check(!ovf_pulse, "R9 single-cycle pulse", ovf_pulse, 0);
    repeat (11) @(negedge clk);
    check(lo_q == 8'hE1 && hi_q == 8'h00, "R9 continues after wrap", {hi_q, lo_q}, 16'h00E1);

    // R7: FF9C in 16-bit mode
    run_en = 0; mode = 2'b01;
    wr(0, 8'h9C); wr(1, 8'hFF);
    push("R7 16-bit wrap", 8'h00, 8'h00);
    run_en = 1;
    wait_lo_change(c0);
    check(lo_q == 8'h9D, "R7 first increment", lo_q, 8'h9D);
    wait_ovf(1, 1500);
    check(ovf_cyc - c0 == 99 * 12, "R7 100 increments", ovf_cyc - c0, 99 * 12);

    // R8: auto-reload with 0xC0
    run_en = 0; mode = 2'b10;
    wr(1, 8'hC0); wr(0, 8'hFE);
    for (int k = 0; k < 3; k++) push("R8 reload value", 8'hC0, 8'hC0);
    run_en = 1;
    wait_ovf(2, 1000);
    c1 = ovf_cyc;
    wait_ovf(1, 1000);
    c2 = ovf_cyc;
    check(c2 - c1 == 64 * 12, "R8 reload period", c2 - c1, 64 * 12);
    check(hi_q == 8'hC0, "R8 high byte kept", hi_q, 8'hC0);

    // R3: event counting
    run_en = 0; mode = 2'b01; count_sel = 1; evt_pin = 0;
    wr(0, 8'h00); wr(1, 8'h00);
    run_en = 1;
    repeat (30) @(negedge clk);
    for (int p = 0; p < 5; p++) begin
      evt_pin = 1; repeat (24) @(negedge clk);
      evt_pin = 0; repeat (24) @(negedge clk);
    end
    check(lo_q == 8'd5, "R3 five falling edges", lo_q, 5);
    evt_pin = 1;
    repeat (60) @(negedge clk);
    check(lo_q == 8'd5, "R3 rising edge and high level", lo_q, 5);
    evt_pin = 0;
    repeat (30) @(negedge clk);
    check(lo_q == 8'd6, "R3 next falling edge", lo_q, 6);

    check(exp_q.size() == 0, "R9 all expected wraps seen", exp_q.size(), 0);
    summary();
  end
endmodule